// File: doc/BRIEF.md
# Pipelined Half-Precision Fused Multiply-Add

This block evaluates Y = A×B + C on 16-bit binary floating-point operands. It rounds once, to nearest with ties to even. A new operand set may enter on every clock. The result comes out of a four-stage pipeline, and a valid flag travels with each operation. The multiply is split over two stages. The low product bits are formed in stage one, together with the exponent arithmetic. The upper product bits pass through a carry look-ahead adder in stage two, where both addends are also aligned to the larger exponent. Stage three does the signed add or subtract and counts leading zeros. Stage four normalizes, rounds and saturates.

Operands are ordinary normal numbers. An exponent field of zero means the value zero, so there are no subnormals. Results that overflow become infinity. Results too small for a normal number become a signed zero. There is no NaN handling and there are no exception flags.

Top module: `fma16_pipe`

## Requirements
- R1: Operands and result share one layout: the sign is in bit 15, the biased exponent (bias 15) in bits 14:10 and the fraction in bits 9:0, with an implicit leading one. Inputs with exponent field 31 are unsupported and never applied.
- R2: An operation sampled with `in_valid` high at a rising edge appears on `y`, with `out_valid` high, right after the fourth rising edge, counting the sampling edge as the first. One operation can be accepted on every cycle.
- R3: For normal operands, `y` is the exact value of A×B+C rounded once to 11 significant bits, to nearest, with ties going to the even fraction.
- R4: An operand with exponent field 0 is the value zero. If A or B is zero, `y` equals C bit for bit. If C is also zero, the R5 rule applies.
- R5: An exact zero sum, from cancellation or from all-zero operands, gives `y` = 0x0000.
- R6: A rounded result whose biased exponent is 31 or more gives infinity with the result's sign: exponent field 31 and fraction 0.
- R7: A nonzero rounded result whose biased exponent is 0 or less gives a zero carrying the result's sign: exponent 0 and fraction 0.
- R8: When the signs of the product and of C differ, the magnitudes are subtracted, and the result sign is that of the larger-magnitude term.
- R9: A rounding increment that carries out of the fraction makes the fraction 0 and adds one to the exponent.
- R10: A synchronous active-high `rst` clears every pipeline register. After a reset edge, `out_valid` is 0 and `y` is 0x0000.
- R11: When `out_valid` is low, `y` keeps the last valid result. A cycle with `in_valid` low enters a bubble and does not disturb `y`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on `a`, `b`, `c` are to be processed |
| a | input | 16 | Multiplicand |
| b | input | 16 | Multiplier |
| c | input | 16 | Addend |
| out_valid | output | 1 | `y` holds a new result this cycle |
| y | output | 16 | Rounded result |

## Verification
On every cycle, the checker confirms four things. The valid flag has a four-edge delay. `y` holds still whenever `out_valid` is low. Any zero or saturated exponent field comes with a zero fraction. A zero product returns the addend unchanged. Whether a result is rounded correctly cannot be seen by a property, and neither can the subtraction sign, cancellation, or a rounding carry that moves into the exponent. These are shown only by the bench. It compares the design's output against an exact wide-integer model, using seeded random operands with clustered exponents together with directed ties, overflows and underflows.

// File: rtl/fma16_pkg.sv
package fma16_pkg;
   localparam int HP_EXP_W  = 5;
   localparam int HP_FRAC_W = 10;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } eff_op_e;
endpackage

// File: rtl/fma16_cla.sv
module fma16_cla #(
   parameter int WIDTH   = 15,
   parameter int GROUP   = 4,
   parameter bit USE_CLA = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] sum_o
);
   if (GROUP < 2) begin : g_bad_group
      $error("fma16_cla: GROUP must be at least 2");
   end

   if (USE_CLA) begin : g_cla
      logic [WIDTH-1:0] carry;
      always_comb begin
         carry[0] = 1'b0;
         for (int i = 1; i < WIDTH; i++) begin
            int   base;
            logic gg;
            logic pp;
            base = ((i % GROUP) == 0) ? i - GROUP : (i / GROUP) * GROUP;
            gg = 1'b0;
            pp = 1'b1;
            for (int j = 0; j < WIDTH; j++) begin
               if (j >= base && j < i) begin
                  gg = (a_i[j] & b_i[j]) | ((a_i[j] ^ b_i[j]) & gg);
                  pp = pp & (a_i[j] ^ b_i[j]);
               end
            end
            carry[i] = gg | (pp & carry[base]);
         end
      end
      assign sum_o = a_i ^ b_i ^ carry;
   end else begin : g_ripple
      assign sum_o = a_i + b_i;
   end
endmodule

// File: rtl/fma16_lzc.sv
module fma16_lzc #(
   parameter int WIDTH = 26,
   localparam int CW   = $clog2(WIDTH + 1)
) (
   input  logic [WIDTH-1:0] val_i,
   output logic [CW-1:0]    cnt_o
);
   always_comb begin
      cnt_o = CW'(WIDTH);
      for (int i = 0; i < WIDTH; i++) begin
         if (val_i[i]) cnt_o = CW'(WIDTH - 1 - i);
      end
   end
endmodule

// File: rtl/fma16_shr_sticky.sv
module fma16_shr_sticky #(
   parameter int WIDTH = 26,
   parameter int SH_W  = 5
) (
   input  logic [WIDTH-1:0] val_i,
   input  logic [SH_W-1:0]  sh_i,
   output logic [WIDTH-1:0] val_o
);
   logic [WIDTH-1:0] shifted;
   logic [WIDTH-1:0] lost;

   assign shifted = val_i >> sh_i;
   assign lost    = val_i & ~({WIDTH{1'b1}} << sh_i);
   assign val_o   = {shifted[WIDTH-1:1], shifted[0] | (|lost)};
endmodule

// File: rtl/fma16_pipe.sv
module fma16_pipe
   import fma16_pkg::*;
#(
   parameter int EXP_W   = HP_EXP_W,
   parameter int FRAC_W  = HP_FRAC_W,
   parameter int LOW_W   = 7,
   parameter int GUARD_W = 3,
   parameter bit USE_CLA = 1'b1,
   localparam int W      = 1 + EXP_W + FRAC_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic         out_valid,
   output logic [W-1:0] y
);
   localparam int MW    = FRAC_W + 1;
   localparam int PW    = 2 * MW;
   localparam int HI_W  = MW - LOW_W;
   localparam int PL_W  = MW + LOW_W;
   localparam int TOP_W = PW - LOW_W;
   localparam int FW    = PW + GUARD_W + 1;
   localparam int OFS   = FW - 1 - (PW - 2 + GUARD_W);
   localparam int EI_W  = EXP_W + 3;
   localparam int SH_W  = $clog2(FW + 1);
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
   localparam int EMAX  = (1 << EXP_W) - 1;

   if (EXP_W < 3)                  begin : g_bad_exp   $error("EXP_W too small");       end
   if (LOW_W < 1 || LOW_W >= MW)   begin : g_bad_low   $error("LOW_W out of range");    end
   if (GUARD_W < 3)                begin : g_bad_guard $error("GUARD_W must be >= 3");  end

   function automatic logic [SH_W-1:0] clamp_sh(input logic signed [EI_W-1:0] d);
      if (d <= 0)                         return '0;
      else if (d >= $signed(EI_W'(FW)))   return SH_W'(FW);
      else                                return SH_W'(d);
   endfunction

   // ---------------- stage 1: low product bits, exponent calculation
   logic [EXP_W-1:0] ea, eb, ec;
   logic [MW-1:0]    ma, mb, mc;
   logic             pz, cz;
   logic signed [EI_W-1:0] ep_c, ec_c, emax_c;
   logic [PL_W-1:0]  pl_c;

   assign ea = a[W-2 -: EXP_W];
   assign eb = b[W-2 -: EXP_W];
   assign ec = c[W-2 -: EXP_W];
   assign pz = (ea == '0) || (eb == '0);
   assign cz = (ec == '0);
   assign ma = (ea == '0) ? '0 : {1'b1, a[FRAC_W-1:0]};
   assign mb = (eb == '0) ? '0 : {1'b1, b[FRAC_W-1:0]};
   assign mc = cz ? '0 : {1'b1, c[FRAC_W-1:0]};
   assign pl_c = PL_W'(ma) * PL_W'(mb[LOW_W-1:0]);

   always_comb begin
      ep_c = $signed(EI_W'(ea)) + $signed(EI_W'(eb)) - $signed(EI_W'(BIAS));
      ec_c = $signed(EI_W'(ec));
      if (pz)                emax_c = ec_c;
      else if (cz)           emax_c = ep_c;
      else if (ep_c > ec_c)  emax_c = ep_c;
      else                   emax_c = ec_c;
   end

   logic                   s1_v, s1_sp;
   eff_op_e                s1_op;
   logic signed [EI_W-1:0] s1_e;
   logic [SH_W-1:0]        s1_dp, s1_dc;
   logic [MW-1:0]          s1_ma, s1_mc;
   logic [HI_W-1:0]        s1_mbhi;
   logic [LOW_W-1:0]       s1_plo;
   logic [MW-1:0]          s1_phi;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_v <= 1'b0; s1_sp <= 1'b0; s1_op <= OP_ADD; s1_e <= '0;
         s1_dp <= '0; s1_dc <= '0; s1_ma <= '0; s1_mc <= '0;
         s1_mbhi <= '0; s1_plo <= '0; s1_phi <= '0;
      end else begin
         s1_v    <= in_valid;
         s1_sp   <= a[W-1] ^ b[W-1];
         s1_op   <= ((a[W-1] ^ b[W-1]) != c[W-1]) ? OP_SUB : OP_ADD;
         s1_e    <= emax_c;
         s1_dp   <= pz ? '0 : clamp_sh(emax_c - ep_c);
         s1_dc   <= cz ? '0 : clamp_sh(emax_c - ec_c);
         s1_ma   <= ma;
         s1_mc   <= mc;
         s1_mbhi <= mb[MW-1:LOW_W];
         s1_plo  <= pl_c[LOW_W-1:0];
         s1_phi  <= pl_c[PL_W-1:LOW_W];
      end
   end

   // ---------------- stage 2: upper product bits, alignment
   logic [TOP_W-1:0] hi_pp, top_c;
   logic [FW-1:0]    xa_c, ca_c, xs_c, cs_c;

   assign hi_pp = TOP_W'(s1_ma) * TOP_W'(s1_mbhi);

   fma16_cla #(.WIDTH(TOP_W), .USE_CLA(USE_CLA)) u_cla (
      .a_i(TOP_W'(s1_phi)), .b_i(hi_pp), .sum_o(top_c));

   assign xa_c = {1'b0, top_c, s1_plo, {GUARD_W{1'b0}}};
   assign ca_c = {2'b00, s1_mc, {FRAC_W{1'b0}}, {GUARD_W{1'b0}}};

   fma16_shr_sticky #(.WIDTH(FW), .SH_W(SH_W)) u_shp (.val_i(xa_c), .sh_i(s1_dp), .val_o(xs_c));
   fma16_shr_sticky #(.WIDTH(FW), .SH_W(SH_W)) u_shc (.val_i(ca_c), .sh_i(s1_dc), .val_o(cs_c));

   logic                   s2_v, s2_sp;
   eff_op_e                s2_op;
   logic signed [EI_W-1:0] s2_e;
   logic [FW-1:0]          s2_x, s2_c;

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_v <= 1'b0; s2_sp <= 1'b0; s2_op <= OP_ADD; s2_e <= '0; s2_x <= '0; s2_c <= '0;
      end else begin
         s2_v <= s1_v; s2_sp <= s1_sp; s2_op <= s1_op; s2_e <= s1_e; s2_x <= xs_c; s2_c <= cs_c;
      end
   end

   // ---------------- stage 3: add/subtract, sign, leading-zero count
   logic [FW-1:0]   sum_c, dxc_c, dcx_c, mag_c;
   logic            cgt_c, sign_c;
   logic [SH_W-1:0] lz_c;

   assign sum_c = s2_x + s2_c;
   assign dxc_c = s2_x - s2_c;
   assign dcx_c = s2_c - s2_x;
   assign cgt_c = s2_c > s2_x;

   always_comb begin
      if (s2_op == OP_SUB) begin
         mag_c  = cgt_c ? dcx_c : dxc_c;
         sign_c = cgt_c ? ~s2_sp : s2_sp;
      end else begin
         mag_c  = sum_c;
         sign_c = s2_sp;
      end
   end

   fma16_lzc #(.WIDTH(FW)) u_lzc (.val_i(mag_c), .cnt_o(lz_c));

   logic                   s3_v, s3_s, s3_z;
   logic signed [EI_W-1:0] s3_e;
   logic [FW-1:0]          s3_m;
   logic [SH_W-1:0]        s3_lz;

   always_ff @(posedge clk) begin
      if (rst) begin
         s3_v <= 1'b0; s3_s <= 1'b0; s3_z <= 1'b0; s3_e <= '0; s3_m <= '0; s3_lz <= '0;
      end else begin
         s3_v <= s2_v; s3_s <= sign_c; s3_z <= (mag_c == '0);
         s3_e <= s2_e; s3_m <= mag_c; s3_lz <= lz_c;
      end
   end

   // ---------------- stage 4: normalize, round, overflow
   logic [FW-1:0]          norm_c;
   logic [MW-1:0]          mant_c;
   logic                   grd_c, stk_c, up_c, rc_c, ovf_c, unf_c;
   logic [FRAC_W-1:0]      frac_c;
   logic signed [EI_W-1:0] er_c;
   logic [W-1:0]           res_c;

   assign norm_c = s3_m << s3_lz;
   assign mant_c = norm_c[FW-1 -: MW];
   assign grd_c  = norm_c[FW-MW-1];
   assign stk_c  = |norm_c[FW-MW-2:0];
   assign up_c   = grd_c & (stk_c | mant_c[0]);
   assign rc_c   = up_c & (&mant_c);
   assign frac_c = mant_c[FRAC_W-1:0] + FRAC_W'(up_c);
   assign er_c   = s3_e + $signed(EI_W'(OFS)) - $signed(EI_W'(s3_lz)) + $signed(EI_W'(rc_c));
   assign ovf_c  = er_c >= $signed(EI_W'(EMAX));
   assign unf_c  = er_c <= $signed(EI_W'(0));

   always_comb begin
      if (s3_z)       res_c = '0;
      else if (ovf_c) res_c = {s3_s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else if (unf_c) res_c = {s3_s, {(W-1){1'b0}}};
      else            res_c = {s3_s, er_c[EXP_W-1:0], frac_c};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         y         <= '0;
      end else begin
         out_valid <= s3_v;
         if (s3_v) y <= res_c;
      end
   end
endmodule

// File: rtl/fma16_pipe_chk.sv
module fma16_pipe_chk #(
   parameter int EXP_W  = 5,
   parameter int FRAC_W = 10,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [EXP_W-1:0] a_exp,
   input logic [EXP_W-1:0] b_exp,
   input logic [W-1:0]     c,
   input logic             out_valid,
   input logic [W-1:0]     y
);
   logic [3:0]   vq, pzq;
   logic [W-1:0] cq [4];

   always_ff @(posedge clk) begin
      if (rst) begin
         vq  <= '0;
         pzq <= '0;
         for (int i = 0; i < 4; i++) cq[i] <= '0;
      end else begin
         vq  <= {vq[2:0], in_valid};
         pzq <= {pzq[2:0], (a_exp == '0) || (b_exp == '0)};
         cq[0] <= c;
         for (int i = 1; i < 4; i++) cq[i] <= cq[i-1];
      end
   end

   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid == vq[3]);

   assert_zero_product_R4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && vq[3] && pzq[3]) |->
         (y == ((cq[3][W-2 -: EXP_W] == '0) ? '0 : cq[3])));

   assert_inf_form_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && y[W-2 -: EXP_W] == {EXP_W{1'b1}}) |-> (y[FRAC_W-1:0] == '0));

   assert_zero_form_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && y[W-2 -: EXP_W] == '0) |-> (y[FRAC_W-1:0] == '0));

   assert_reset_clear_R10: assert property (@(posedge clk)
      rst |=> (!out_valid && y == '0));

   assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(y));
endmodule

bind fma16_pipe fma16_pipe_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid),
   .a_exp(a[W-2 -: EXP_W]), .b_exp(b[W-2 -: EXP_W]), .c(c),
   .out_valid(out_valid), .y(y));

// File: tb/sim_fma16_pipe.sv
`timescale 1ns/1ps
module sim_fma16_pipe;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] a = '0, b = '0, c = '0;
   logic        out_valid;
   logic [15:0] y;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   logic        ev  [16];
   logic [15:0] ey  [16];
   bit          wr  [16];
   string       etg [16];
   logic [15:0] last_y = '0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fma16_pipe u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b), .c(c),
                  .out_valid(out_valid), .y(y));

   // exact reference: all values scaled by 2^48 into a wide integer
   function automatic logic [15:0] ref_fma(input logic [15:0] xa, xb, xc);
      logic [99:0] pm, cm, mag, rem, half;
      int ea, eb, ec, L, er, sh, mant;
      logic sp, sc, s, up;
      ea = int'(xa[14:10]); eb = int'(xb[14:10]); ec = int'(xc[14:10]);
      sp = xa[15] ^ xb[15]; sc = xc[15];
      pm = '0; cm = '0;
      if (ea != 0 && eb != 0)
         pm = (100'({1'b1, xa[9:0]}) * 100'({1'b1, xb[9:0]})) << (ea + eb - 2);
      if (ec != 0) cm = 100'({1'b1, xc[9:0]}) << (ec + 23);
      if (sp == sc)     begin mag = pm + cm; s = sp; end
      else if (pm >= cm) begin mag = pm - cm; s = sp; end
      else              begin mag = cm - pm; s = sc; end
      if (mag == '0) return 16'h0000;
      L = 0;
      for (int i = 0; i < 100; i++) if (mag[i]) L = i;
      er = L - 33;
      up = 1'b0;
      if (L > 10) begin
         sh   = L - 10;
         mant = int'(mag >> sh);
         rem  = mag & ((100'(1) << sh) - 100'(1));
         half = 100'(1) << (sh - 1);
         up   = (rem > half) || (rem == half && mant[0]);
      end else begin
         mant = int'(mag << (10 - L));
      end
      mant = mant + int'(up);
      if (mant == 2048) begin mant = 1024; er = er + 1; end
      if (er >= 31) return {s, 5'h1f, 10'h000};
      if (er <= 0)  return {s, 15'h0000};
      return {s, 5'(er), 10'(mant)};
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic v, input logic [15:0] xa, xb, xc, input string tag);
      int slot;
      @(negedge clk);
      in_valid = v; a = xa; b = xb; c = xc;
      slot = (cyc + 4) % 16;
      if (v) last_y = ref_fma(xa, xb, xc);
      ev[slot] = v; ey[slot] = last_y; etg[slot] = tag; wr[slot] = 1'b1;
   endtask

   // R2 / R11 / value checks, sampled mid-cycle
   always @(negedge clk) begin
      int idx;
      idx = cyc % 16;
      if (!rst && wr[idx]) begin
         wr[idx] = 1'b0;
         check({etg[idx], " R2 valid"}, {15'h0, out_valid}, {15'h0, ev[idx]});
         check(ev[idx] ? etg[idx] : "R11 hold", y, ey[idx]);
      end
   end

   function automatic logic [15:0] rnd_op();
      logic [15:0] v;
      v = 16'($urandom);
      if (v[14:10] == 5'h1f) v[14:10] = 5'h1e;
      if (($urandom % 12) == 0) v[14:10] = 5'h00;
      return v;
   endfunction

   initial begin
      for (int i = 0; i < 16; i++) begin wr[i] = 1'b0; ev[i] = 1'b0; ey[i] = '0; end
      void'($urandom(32'h5EED_0A17));
      repeat (3) @(negedge clk);
      check("R10 reset valid", {15'h0, out_valid}, 16'h0);
      check("R10 reset y", y, 16'h0000);
      rst = 1'b0;

      issue(1, 16'h4000, 16'h4200, 16'h3C00, "R1 2*3+1");
      issue(1, 16'h0000, 16'h4500, 16'h4248, "R4 zero A");
      issue(1, 16'h4500, 16'h0000, 16'hC248, "R4 zero B");
      issue(1, 16'h3C00, 16'h3C00, 16'hBC00, "R5 cancel");
      issue(1, 16'h0000, 16'h8000, 16'h0000, "R5 all zero");
      issue(1, 16'h7BFF, 16'h4000, 16'h0000, "R6 ovf pos");
      issue(1, 16'hFBFF, 16'h4000, 16'h3C00, "R6 ovf neg");
      issue(1, 16'h0400, 16'h0400, 16'h0000, "R7 unf pos");
      issue(1, 16'h8400, 16'h0400, 16'h0000, "R7 unf neg");
      issue(1, 16'h3C00, 16'hC000, 16'h4200, "R8 C larger");
      issue(1, 16'h3C00, 16'h4200, 16'hC000, "R8 product larger");
      issue(1, 16'h3BFF, 16'h3C00, 16'h0C00, "R9 carry");
      issue(1, 16'h3C00, 16'h3C00, 16'h1000, "R3 tie even down");
      issue(1, 16'h3C01, 16'h3C00, 16'h1000, "R3 tie even up");
      issue(0, 16'h7BFF, 16'h7BFF, 16'h7BFF, "R11 bubble");
      issue(0, 16'h1234, 16'h4321, 16'h5555, "R11 bubble");
      issue(1, 16'h3C00, 16'h3C00, 16'h3C00, "R2 after bubble");

      for (int n = 0; n < 1500; n++) begin
         logic [15:0] xa, xb, xc;
         int pe;
         xa = rnd_op(); xb = rnd_op(); xc = rnd_op();
         if (n % 3 != 0 && xa[14:10] != 0 && xb[14:10] != 0) begin
            pe = int'(xa[14:10]) + int'(xb[14:10]) - 15 + int'($urandom % 25) - 12;
            if (pe < 1) pe = 1;
            if (pe > 30) pe = 30;
            xc[14:10] = 5'(pe);
         end
         issue(($urandom % 8) != 0, xa, xb, xc, "R3 random");
      end

      repeat (6) @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R10 mid reset valid", {15'h0, out_valid}, 16'h0);
      check("R10 mid reset y", y, 16'h0000);
      rst = 1'b0;
      @(negedge clk);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule